// File: doc/BRIEF.md
# Masked Watchpoint Comparator Unit

This unit holds a small set of programmable watchpoint comparators behind a plain 32-bit register bus. It observes one bus transfer per cycle and raises a match pulse for each comparator that the transfer hits. A transfer is described by its address, data, access size, a flag that tells an instruction fetch from a data access, and a valid strobe.

Each comparator has a 32-bit reference register and a mask register. In address mode, a comparator matches when the observed address equals the reference on every bit above a power-of-two ignore window. The window size comes from the mask register, which hardware clamps when it is written. A comparator set to watch fetches also ignores address bit 0 when its mask is zero, since fetches are always at least halfword aligned. Comparator 0 can instead compare data values. In that mode software replicates a byte or halfword reference across the lanes of the register. The unit then checks only the byte lanes that the access actually carries.

The watch type of each comparator and the value-compare mode of comparator 0 come in as plain inputs. Match outputs are registered.

Top module: `wpt_cmp_unit`

## Requirements
- R1: After reset, every reference and mask register reads back zero and every match output is low.
- R2: Comparator i has its reference register at byte offset 0x20 + 16*i and its mask register at 0x24 + 16*i. The reference register stores and returns all 32 written bits.
- R3: The mask register keeps only write-data bits [4:0]. Its readback bits [31:5] are always zero.
- R4: A write of a mask value above 24 is stored as 24. Values from 0 to 24 are stored unchanged.
- R5: In address mode with a nonzero mask x, address bits [x-1:0] do not take part in the compare. Bits [31:x] must equal the reference. This holds for both watch types.
- R6: In address mode with mask 0, a data watch compares all 32 address bits. A fetch watch (watch_fetch bit = 1) ignores address bit 0.
- R7: An address-mode hit needs obs_valid = 1 and obs_fetch equal to the comparator's watch_fetch bit. obs_fetch = 1 means an instruction fetch and 0 means a data read or write.
- R8: When cmp0_value_mode = 1, comparator 0 matches a valid data transfer (obs_fetch = 0) whose checked byte lanes of obs_data equal the same lanes of its reference. The mask and the watch_fetch bit have no effect in this mode. The size code obs_size selects the lanes: 0 is a byte on lane obs_addr[1:0]; 1 is a halfword on lanes 1:0 when obs_addr[1] = 0 and lanes 3:2 otherwise; 2 and 3 are a word on all four lanes. Lane k is data bits [8k+7:8k].
- R9: A match output goes high in the cycle after the qualifying transfer is sampled, and only for that one cycle per transfer. A cycle with obs_valid = 0 produces no match in the following cycle.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| watch_fetch | input | 2 | Per comparator: 1 watches fetches, 0 watches data accesses |
| cmp0_value_mode | input | 1 | Comparator 0 compares data values instead of addresses |
| obs_valid | input | 1 | Observed transfer valid |
| obs_fetch | input | 1 | Observed transfer is an instruction fetch |
| obs_size | input | 2 | Observed access size: 0 byte, 1 halfword, 2/3 word |
| obs_addr | input | 32 | Observed transfer address |
| obs_data | input | 32 | Observed transfer data |
| match | output | 2 | Registered match pulse, one bit per comparator |

## Verification
The bench builds the unit with its default parameters: two comparators, an 8-bit register offset and a mask ceiling of 24. With these values both register strides and the clamp boundary at 24 and 25 are reachable by directed writes. The random phase reprograms the masks across the full 0 to 31 write range. It draws addresses that differ from the reference only inside or just above the ignore window, so hits and near misses both occur often. It also draws data values that differ from a replicated reference on single lanes, which exercises each size and lane position of the value compare.

// File: rtl/wpt_cmp_unit.sv
module wpt_cmp_unit #(
  parameter int NUM_CMP    = 2,
  parameter int ADDR_W     = 8,
  parameter int MASK_MAX   = 24,
  parameter int REF_BASE   = 32,
  parameter int CMP_STRIDE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wen,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_CMP-1:0] watch_fetch,
  input  logic               cmp0_value_mode,
  input  logic               obs_valid,
  input  logic               obs_fetch,
  input  logic [1:0]         obs_size,
  input  logic [31:0]        obs_addr,
  input  logic [31:0]        obs_data,
  output logic [NUM_CMP-1:0] match
);

  localparam int MW = 5;
  localparam logic [MW-1:0] MASK_CAP = MW'(MASK_MAX);

  logic [31:0]   ref_q  [NUM_CMP];
  logic [MW-1:0] mask_q [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic [MW-1:0] mask_in;
  logic [3:0]    lane_en;
  logic          val_hit;

  assign mask_in = (reg_wdata[MW-1:0] > MASK_CAP) ? MASK_CAP : reg_wdata[MW-1:0];

  function automatic logic [ADDR_W-1:0] ref_off(int i);
    return ADDR_W'(REF_BASE + CMP_STRIDE * i);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        ref_q[i]  <= '0;
        mask_q[i] <= '0;
      end
    end else if (reg_wen) begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (reg_addr == ref_off(i))      ref_q[i]  <= reg_wdata;
        if (reg_addr == ref_off(i) + 4)  mask_q[i] <= mask_in;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (reg_addr == ref_off(i))     reg_rdata = ref_q[i];
      if (reg_addr == ref_off(i) + 4) reg_rdata = {{(32-MW){1'b0}}, mask_q[i]};
    end
  end

  always_comb begin
    case (obs_size)
      2'd0:    lane_en = 4'b0001 << obs_addr[1:0];
      2'd1:    lane_en = obs_addr[1] ? 4'b1100 : 4'b0011;
      default: lane_en = 4'b1111;
    endcase
    val_hit = obs_valid && !obs_fetch;
    for (int k = 0; k < 4; k++)
      if (lane_en[k] && (obs_data[8*k +: 8] != ref_q[0][8*k +: 8])) val_hit = 1'b0;
  end

  always_comb begin
    for (int i = 0; i < NUM_CMP; i++) begin
      logic [31:0] ign;
      ign = (mask_q[i] == '0) ? {31'b0, watch_fetch[i]} : ((32'h1 << mask_q[i]) - 32'h1);
      hit[i] = obs_valid && (obs_fetch == watch_fetch[i]) &&
               (((obs_addr ^ ref_q[i]) & ~ign) == 32'h0);
      if (i == 0 && cmp0_value_mode) hit[i] = val_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match <= '0;
    else        match <= hit;
  end

  // R4
  mask_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wen && reg_addr == ref_off(0) + 4 && reg_wdata[MW-1:0] > MASK_CAP
    |=> mask_q[0] == MASK_CAP);

  // R3
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ref_off(0) + 4 |-> reg_rdata[31:MW] == '0);

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr < ADDR_W'(REF_BASE) |-> reg_rdata == 32'h0);

  // R9
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match != '0 |-> $past(obs_valid));

  // R7
  match_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match[NUM_CMP-1] |-> $past(obs_fetch == watch_fetch[NUM_CMP-1]));

  // R8
  value_mode_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match[0] && $past(cmp0_value_mode) |-> !$past(obs_fetch));

endmodule

// File: tb/tb_wpt_cmp_unit.sv
module tb_wpt_cmp_unit;
  logic        clk = 0, rst_n = 0, reg_wen = 0, cmp0_value_mode = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, obs_addr = 0, obs_data = 0;
  logic [1:0]  watch_fetch = 0, obs_size = 0, match;
  logic        obs_valid = 0, obs_fetch = 0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_ref [2];
  logic [4:0]  m_mask [2];

  always #4 clk = ~clk;

  wpt_cmp_unit dut (.clk, .rst_n, .reg_wen, .reg_addr, .reg_wdata, .reg_rdata,
    .watch_fetch, .cmp0_value_mode, .obs_valid, .obs_fetch, .obs_size,
    .obs_addr, .obs_data, .match);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    obs_valid = 0; reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 0;
    for (int i = 0; i < 2; i++) begin
      if (a == 8'h20 + 8'(16*i)) m_ref[i] = d;
      if (a == 8'h24 + 8'(16*i)) m_mask[i] = (d[4:0] > 5'd24) ? 5'd24 : d[4:0];
    end
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  function automatic logic exp_hit(int i, logic v, logic f, logic [1:0] s,
                                   logic [31:0] a, logic [31:0] d);
    logic [31:0] ign;
    logic [3:0] ln;
    if (!v) return 0;
    if (i == 0 && cmp0_value_mode) begin
      if (f) return 0;
      ln = (s == 0) ? (4'b0001 << a[1:0]) : (s == 1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
      for (int k = 0; k < 4; k++)
        if (ln[k] && d[8*k +: 8] != m_ref[0][8*k +: 8]) return 0;
      return 1;
    end
    if (f != watch_fetch[i]) return 0;
    ign = (m_mask[i] == 0) ? (watch_fetch[i] ? 32'h1 : 32'h0) : ((32'h1 << m_mask[i]) - 1);
    return ((a ^ m_ref[i]) & ~ign) == 0;
  endfunction

  task automatic xfer(string req, logic f, logic [1:0] s, logic [31:0] a, logic [31:0] d);
    logic [1:0] e;
    @(negedge clk);
    obs_valid = 1; obs_fetch = f; obs_size = s; obs_addr = a; obs_data = d;
    e = {exp_hit(1, 1, f, s, a, d), exp_hit(0, 1, f, s, a, d)};
    @(negedge clk);
    obs_valid = 0;
    chk(req, 32'(match), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_ref[0] = 0; m_ref[1] = 0; m_mask[0] = 0; m_mask[1] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1", 8'h20, 0); rd("R1", 8'h24, 0); rd("R1", 8'h30, 0); rd("R1", 8'h34, 0);
    chk("R1", 32'(match), 0);
    // R2 reference map and full width
    wr(8'h20, 32'hDEADBEEF); wr(8'h30, 32'h8000_0001);
    rd("R2", 8'h20, 32'hDEADBEEF); rd("R2", 8'h30, 32'h8000_0001);
    // R3 mask field width
    wr(8'h24, 32'hFFFF_FFE7); rd("R3", 8'h24, 32'h7);
    // R4 clamp
    wr(8'h34, 32'd31); rd("R4", 8'h34, 24);
    wr(8'h34, 32'd25); rd("R4", 8'h34, 24);
    wr(8'h34, 32'd24); rd("R4", 8'h34, 24);
    wr(8'h34, 32'd23); rd("R4", 8'h34, 23);
    // R10 unmapped accesses
    wr(8'h28, 32'h1234_5678); wr(8'h00, 32'hFFFF_FFFF); wr(8'h40, 32'h5);
    rd("R10", 8'h28, 0); rd("R10", 8'h00, 0); rd("R10", 8'h40, 0);
    rd("R10", 8'h20, 32'hDEADBEEF); rd("R10", 8'h24, 7);
    rd("R10", 8'h30, 32'h8000_0001); rd("R10", 8'h34, 23);
    // R6 mask zero
    wr(8'h20, 32'h0000_1000); wr(8'h24, 0);
    watch_fetch = 2'b01;
    xfer("R6", 1, 2, 32'h0000_1001, 0);
    xfer("R6", 1, 2, 32'h0000_1002, 0);
    watch_fetch = 2'b00;
    xfer("R6", 0, 2, 32'h0000_1001, 0);
    xfer("R6", 0, 2, 32'h0000_1000, 0);
    // R5 nonzero mask
    wr(8'h24, 4);
    xfer("R5", 0, 2, 32'h0000_100F, 0);
    xfer("R5", 0, 2, 32'h0000_1010, 0);
    // R7 type mismatch
    xfer("R7", 1, 2, 32'h0000_1000, 0);
    // R9 single pulse: valid then idle
    xfer("R9", 0, 2, 32'h0000_1000, 0);
    @(negedge clk); chk("R9", 32'(match), 0);
    // R8 value compare
    cmp0_value_mode = 1;
    wr(8'h20, 32'hA5A5_A5A5);
    xfer("R8", 0, 0, 32'h3, 32'hA500_0000);
    xfer("R8", 0, 0, 32'h2, 32'hA500_0000);
    wr(8'h20, 32'h1234_1234);
    xfer("R8", 0, 1, 32'h2, 32'h1234_0000);
    xfer("R8", 0, 1, 32'h0, 32'h1234_0000);
    xfer("R8", 1, 2, 32'h0, 32'h1234_1234);
    cmp0_value_mode = 0;
    // random phase
    for (int it = 0; it < 3000; it++) begin
      if (it % 40 == 0) begin
        for (int i = 0; i < 2; i++) begin
          wr(8'h20 + 8'(16*i), $urandom);
          wr(8'h24 + 8'(16*i), $urandom_range(0, 31));
          rd("R4", 8'h24 + 8'(16*i), 32'(m_mask[i]));
        end
        watch_fetch = 2'($urandom);
        cmp0_value_mode = ($urandom_range(0, 2) == 0);
        if (cmp0_value_mode && $urandom_range(0, 1) == 1)
          wr(8'h20, {4{8'($urandom)}});
      end
      begin
        int i = $urandom_range(0, 1);
        logic [31:0] a, d, fl;
        fl = ($urandom_range(0, 3) == 0) ? $urandom
             : ($urandom & ((32'h1 << $urandom_range(0, 26)) - 1));
        a = m_ref[i] ^ fl;
        d = m_ref[0];
        if ($urandom_range(0, 2) == 0) d[8*$urandom_range(0, 3) +: 8] ^= 8'($urandom_range(1, 255));
        xfer(cmp0_value_mode ? "R8 random" : "R5/R6/R7 random",
             1'($urandom), 2'($urandom), a, d);
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule